// File: doc/BRIEF.md
# Per-Line Trigger-Mode Interrupt Controller

This block gathers a set of interrupt request inputs and presents one interrupt to a processor, together with the number of the line that should be served. Each request input may carry the OR of several devices. The block sees only that combined wire. Software picks a trigger mode for each line at startup. A level line requests service for as long as its input is high. An edge line records a request only when its input rises.

The processor takes the reported line into service with a one-cycle acknowledge strobe. It ends service by writing an end-of-interrupt (EOI) that names the line. What happens after that write depends on the line's mode. A level line whose input is still high interrupts again at once. An edge line whose input is still high stays quiet until the input falls and rises again. The case of a shared line whose input stays high because a second device raised it during service is therefore handled only by level mode.

All request inputs pass through a two-flop synchroniser first. Priority is fixed: the lowest-numbered eligible line wins. The interrupt and line-number outputs are registered.

Top module: `irq_trigger_ctrl`

## Requirements
- R1: A level-mode line that is not in service raises `irq_o` while its synchronised input is high. If the input falls before the acknowledge, the request is withdrawn and `irq_o` drops.
- R2: After an EOI for a level-mode line whose input is still high, `irq_o` rises again for that line without any transition of the input.
- R3: An edge-mode line records a request only on a low-to-high transition of its input. An input held high records nothing more.
- R4: After an EOI for an edge-mode line whose input is still high, no interrupt is raised. A new request needs the input to fall and then rise.
- R5: A rising edge on an edge-mode line while that line is in service is remembered. It is presented once the EOI for that line arrives.
- R6: `irq_o` is high when at least one line is pending and not in service. `line_o` gives the lowest-numbered such line, and `line_o` is 0 whenever `irq_o` is low.
- R7: An `ack` pulse while `irq_o` is high moves the line shown on `line_o` into service. An `ack` while `irq_o` is low has no effect.
- R8: A write with `wr_sel`=1 is an EOI. `wr_data[IDX_W-1:0]` holds the line number, and the write clears that line's in-service state.
- R9: A write with `wr_sel`=0 sets the modes. Bit i of `wr_data` set to 1 makes line i level-triggered, and 0 makes it edge-triggered. EOI writes leave the modes unchanged.
- R10: A synchronous reset clears all pending and in-service state, drives `irq_o` and `line_o` to 0, and puts every line in edge mode.
- R11: A request input driven as the OR of several devices acts as one line. On a level line, a second device that keeps the input high across an EOI causes a new interrupt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_in | input | N | Asynchronous request inputs, active high, one per line |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0: mode write, 1: EOI write |
| wr_data | input | N | Mode mask, or line number in the low bits for EOI |
| ack | input | 1 | One-cycle acknowledge of the reported line |
| irq_o | output | 1 | Interrupt to the processor |
| line_o | output | IDX_W | Number of the line being reported |

## Verification
The assertions assume three things: `ack` comes as isolated one-cycle pulses, an EOI names a line inside the range 0 to N-1, and `rst` is held for at least one clock edge. The bench drives every strobe for exactly one cycle from the falling edge. After each strobe it waits several cycles, so `ack` always refers to settled outputs, and it uses only valid line numbers. The request inputs are changed only in bench steps spaced well beyond the synchroniser depth.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic {
    WR_MODE = 1'b0,
    WR_EOI  = 1'b1
  } wr_kind_e;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= '0;
    end else begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/irq_line.sv
module irq_line (
  input  logic clk,
  input  logic rst,
  input  logic level,
  input  logic req_s,
  input  logic ack_hit,
  input  logic eoi_hit,
  output logic active
);
  logic prev_q;
  logic pend_q;
  logic svc_q;
  logic rise;

  assign rise = req_s & ~prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
      svc_q  <= 1'b0;
    end else begin
      prev_q <= req_s;
      if (level)        pend_q <= 1'b0;
      else if (rise)    pend_q <= 1'b1;
      else if (ack_hit) pend_q <= 1'b0;
      if (ack_hit)      svc_q <= 1'b1;
      else if (eoi_hit) svc_q <= 1'b0;
    end
  end

  assign active = ~svc_q & (level ? req_s : pend_q);

  // R3
  pend_set_needs_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pend_q) |-> $past(rise) && !$past(level));
  // R7
  svc_set_only_on_ack_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(svc_q) |-> $past(ack_hit));
  // R8
  svc_clear_only_on_eoi_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(svc_q) |-> $past(eoi_hit));
endmodule

// File: rtl/irq_prio.sv
module irq_prio #(
  parameter int N     = 8,
  parameter int IDX_W = 3
) (
  input  logic [N-1:0]     active,
  output logic             any,
  output logic [IDX_W-1:0] idx,
  output logic [N-1:0]     grant
);
  always_comb begin
    any   = 1'b0;
    idx   = '0;
    grant = '0;
    for (int i = 0; i < N; i++) begin
      if (active[i] && !any) begin
        any      = 1'b1;
        idx      = IDX_W'(i);
        grant[i] = 1'b1;
      end
    end
  end

  // R6
  always_comb begin
    grant_onehot_chk: assert ($onehot0(grant));
    grant_subset_chk: assert ((grant & ~active) == '0);
  end
endmodule

// File: rtl/irq_trigger_ctrl.sv
module irq_trigger_ctrl #(
  parameter int N           = 8,
  parameter int SYNC_STAGES = 2,
  localparam int IDX_W      = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N-1:0]     req_in,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [N-1:0]     wr_data,
  input  logic             ack,
  output logic             irq_o,
  output logic [IDX_W-1:0] line_o
);
  import irq_pkg::*;

  logic [N-1:0]     req_s;
  logic [N-1:0]     mode_q;
  logic [N-1:0]     active;
  logic [N-1:0]     ack_hit;
  logic [N-1:0]     eoi_hit;
  logic [N-1:0]     grant;
  logic             any;
  logic [IDX_W-1:0] idx;
  logic             mode_wr;
  logic             eoi_wr;

  assign mode_wr = wr_en && (wr_kind_e'(wr_sel) == WR_MODE);
  assign eoi_wr  = wr_en && (wr_kind_e'(wr_sel) == WR_EOI);

  irq_sync #(.W(N), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(req_in), .q(req_s)
  );

  always_ff @(posedge clk) begin
    if (rst)          mode_q <= '0;
    else if (mode_wr) mode_q <= wr_data;
  end

  generate
    for (genvar i = 0; i < N; i++) begin : g_line
      assign ack_hit[i] = ack && irq_o && (line_o == IDX_W'(i));
      assign eoi_hit[i] = eoi_wr && (wr_data[IDX_W-1:0] == IDX_W'(i));
      irq_line u_line (
        .clk    (clk),
        .rst    (rst),
        .level  (mode_q[i]),
        .req_s  (req_s[i]),
        .ack_hit(ack_hit[i]),
        .eoi_hit(eoi_hit[i]),
        .active (active[i])
      );
    end
  endgenerate

  irq_prio #(.N(N), .IDX_W(IDX_W)) u_prio (
    .active(active), .any(any), .idx(idx), .grant(grant)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o  <= 1'b0;
      line_o <= '0;
    end else begin
      irq_o  <= any;
      line_o <= idx;
    end
  end

  // R6
  line_zero_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !irq_o |-> line_o == '0);
  // R9
  mode_kept_on_eoi_chk: assert property (@(posedge clk) disable iff (rst)
    eoi_wr |=> $stable(mode_q));
  // R7
  ack_single_line_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ack_hit));
endmodule

// File: tb/tb_irq_trigger_ctrl.sv
module tb_irq_trigger_ctrl;
  localparam int N = 8;
  localparam int IDX_W = 3;
  localparam logic [1:0] OP_IDLE = 2'd0, OP_MODE = 2'd1, OP_ACK = 2'd2, OP_EOI = 2'd3;
  localparam int NV = 27;
  // {req[21:14], op[13:12], arg[11:4], exp_irq[3], exp_line[2:0]}
  localparam logic [21:0] VECS [NV] = '{
    {8'h00, OP_IDLE, 8'h00, 1'b0, 3'd0},
    {8'h00, OP_MODE, 8'h02, 1'b0, 3'd0},
    {8'h01, OP_IDLE, 8'h00, 1'b1, 3'd0},
    {8'h01, OP_ACK,  8'h00, 1'b0, 3'd0},
    {8'h01, OP_EOI,  8'h00, 1'b0, 3'd0},
    {8'h00, OP_IDLE, 8'h00, 1'b0, 3'd0},
    {8'h01, OP_IDLE, 8'h00, 1'b1, 3'd0},
    {8'h01, OP_ACK,  8'h00, 1'b0, 3'd0},
    {8'h02, OP_IDLE, 8'h00, 1'b1, 3'd1},
    {8'h02, OP_ACK,  8'h00, 1'b0, 3'd0},
    {8'h02, OP_EOI,  8'h01, 1'b1, 3'd1},
    {8'h02, OP_ACK,  8'h00, 1'b0, 3'd0},
    {8'h00, OP_EOI,  8'h01, 1'b0, 3'd0},
    {8'h00, OP_EOI,  8'h00, 1'b0, 3'd0},
    {8'h0C, OP_IDLE, 8'h00, 1'b1, 3'd2},
    {8'h0C, OP_ACK,  8'h00, 1'b1, 3'd3},
    {8'h0C, OP_ACK,  8'h00, 1'b0, 3'd0},
    {8'h08, OP_EOI,  8'h02, 1'b0, 3'd0},
    {8'h0C, OP_IDLE, 8'h00, 1'b1, 3'd2},
    {8'h04, OP_ACK,  8'h00, 1'b0, 3'd0},
    {8'h0C, OP_IDLE, 8'h00, 1'b0, 3'd0},
    {8'h0C, OP_EOI,  8'h03, 1'b1, 3'd3},
    {8'h0C, OP_ACK,  8'h00, 1'b0, 3'd0},
    {8'h0C, OP_EOI,  8'h03, 1'b0, 3'd0},
    {8'h0C, OP_EOI,  8'h02, 1'b0, 3'd0},
    {8'h0C, OP_ACK,  8'h00, 1'b0, 3'd0},
    {8'h0D, OP_IDLE, 8'h00, 1'b1, 3'd0}
  };
  localparam string TAGS [NV] = '{
    "R10", "R9", "R3", "R7", "R4", "R3", "R4", "R7", "R1", "R7",
    "R2", "R7", "R8", "R8", "R6", "R6", "R7", "R8", "R3", "R7",
    "R5", "R5", "R7", "R4", "R4", "R7", "R7"
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] req_in = '0;
  logic wr_en = 1'b0, wr_sel = 1'b0, ack = 1'b0;
  logic [N-1:0] wr_data = '0;
  logic irq_o;
  logic [IDX_W-1:0] line_o;
  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic dev_a = 1'b0, dev_b = 1'b0;

  always #4 clk = ~clk;

  irq_trigger_ctrl #(.N(N)) dut (
    .clk(clk), .rst(rst), .req_in(req_in), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .ack(ack), .irq_o(irq_o), .line_o(line_o)
  );

  task automatic chk(input string rq, input logic e_irq, input logic [IDX_W-1:0] e_line);
    checks++;
    if (irq_o !== e_irq || line_o !== e_line) begin
      errors++;
      $display("FAIL %s: irq_o=%0b line_o=%0d expected irq_o=%0b line_o=%0d",
               rq, irq_o, line_o, e_irq, e_line);
    end
  endtask

  task automatic step(input logic [N-1:0] rq, input logic [1:0] op, input logic [N-1:0] arg);
    @(negedge clk);
    req_in = rq;
    wr_en = (op == OP_MODE) || (op == OP_EOI);
    wr_sel = (op == OP_EOI);
    wr_data = arg;
    ack = (op == OP_ACK);
    @(negedge clk);
    wr_en = 1'b0; ack = 1'b0; wr_data = '0;
    repeat (6) @(negedge clk);
  endtask

  task automatic shared(input logic a, input logic b, input logic [1:0] op, input logic [N-1:0] arg);
    dev_a = a; dev_b = b;
    step({6'b0, dev_a | dev_b, 1'b0}, op, arg);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R10", 1'b0, 3'd0);
    rst = 1'b0;
    for (int i = 0; i < NV; i++) begin
      step(VECS[i][21:14], VECS[i][13:12], VECS[i][11:4]);
      chk(TAGS[i], VECS[i][3], VECS[i][2:0]);
    end
    // R10: reset clears everything and returns lines to edge mode
    @(negedge clk);
    rst = 1'b1; req_in = 8'h02;
    repeat (3) @(negedge clk);
    chk("R10", 1'b0, 3'd0);
    rst = 1'b0;
    repeat (6) @(negedge clk);
    chk("R10", 1'b1, 3'd1);
    step(8'h02, OP_ACK, 8'h00);
    step(8'h02, OP_EOI, 8'h01);
    chk("R10", 1'b0, 3'd0);
    // R11: two devices ORed onto level line 1
    step(8'h00, OP_MODE, 8'h02);
    chk("R11", 1'b0, 3'd0);
    shared(1'b1, 1'b0, OP_IDLE, 8'h00);
    chk("R11", 1'b1, 3'd1);
    shared(1'b1, 1'b0, OP_ACK, 8'h00);
    chk("R11", 1'b0, 3'd0);
    shared(1'b1, 1'b1, OP_IDLE, 8'h00);
    shared(1'b0, 1'b1, OP_EOI, 8'h01);
    chk("R11", 1'b1, 3'd1);
    shared(1'b0, 1'b1, OP_ACK, 8'h00);
    shared(1'b0, 1'b0, OP_EOI, 8'h01);
    chk("R1", 1'b0, 3'd0);
    shared(1'b1, 1'b0, OP_IDLE, 8'h00);
    chk("R1", 1'b1, 3'd1);
    shared(1'b0, 1'b0, OP_IDLE, 8'h00);
    chk("R1", 1'b0, 3'd0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule